// File: doc/BRIEF.md
# Five-State JK Excitation Counter

This block is a three-bit synchronous counter built from three behavioural JK flip-flops that share one rising clock edge. The state is read as the three bits C, B and A, with C as the most significant bit. Each flip-flop's J and K inputs come from fixed excitation equations on the current state. No adder and no terminal-count compare is involved. With those equations the counter visits five codes and then wraps.

The three codes outside the cycle (101, 110, 111) have no special handling. Their successors are whatever the same equations produce, and each of them lands back inside the cycle after one clock. An active-high synchronous reset clears the state and overrides the excitation logic. The outputs come straight from the flip-flop registers.

Top module: `mod5_jk_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, the state {C,B,A} becomes 000 after that edge, whatever the J/K logic would otherwise produce.
- R2: Bit A is driven with J = K = NOT C. It inverts at an edge when C is 0 and holds when C is 1.
- R3: Bit B is driven with J = K = A. It inverts at an edge when A is 1 and holds when A is 0.
- R4: Bit C is driven with J = A AND B and K = C. When C is 1 it clears. When C is 0 it sets if A and B are both 1, and otherwise stays 0.
- R5: Starting from 000 the state follows 000, 001, 010, 011, 100 and then returns to 000, so it repeats every five edges. From any of these five codes it never leaves the five-code set.
- R6: From the unused code 101 the next state is 011.
- R7: From the unused code 110 the next state is 010.
- R8: From the unused code 111 the next state is 001.
- R9: All three bits are registered on the same rising edge, and the outputs hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every flip-flop updates on its rising edge |
| rst | input | 1 | Active-high synchronous reset to state 000 |
| outC | output | 1 | State bit C (most significant) |
| outB | output | 1 | State bit B |
| outA | output | 1 | State bit A (least significant) |

## Verification
The properties assume the state changes only through the flip-flops' own edge updates, and that reset is a level sampled at the clock. Every property attempt that begins on an edge with reset high is therefore abandoned. To reach the unused codes, the bench forces the flip-flop registers while reset is held high across an edge. It drops reset and removes the force together between edges, so no property attempt spans the injected jump. The behaviour of reset itself, and the timing of the outputs between edges, are checked by the bench at the ports.

// File: rtl/mod5_pkg.sv
package mod5_pkg;
  // Number of state bits and their positions in the state vector
  localparam int STATE_W = 3;
  localparam int BIT_A   = 0;
  localparam int BIT_B   = 1;
  localparam int BIT_C   = 2;
  localparam int CYCLE_LEN = 5;

  typedef logic [STATE_W-1:0] state_t;

  // Strobes from the excitation logic to the flip-flop bank
  typedef struct packed {
    logic               clr;
    logic [STATE_W-1:0] jIn;
    logic [STATE_W-1:0] kIn;
  } jkCtrl_t;
endpackage

// File: rtl/mod5_jk_ff.sv
module mod5_jk_ff (
  input  logic clk,
  input  logic clr,
  input  logic jIn,
  input  logic kIn,
  output logic qOut
);
  logic qReg;

  // Synchronous clear wins; otherwise hold / clear / set / toggle
  always_ff @(posedge clk) begin
    if (clr) begin
      qReg <= 1'b0;
    end else begin
      unique case ({jIn, kIn})
        2'b00:   qReg <= qReg;
        2'b01:   qReg <= 1'b0;
        2'b10:   qReg <= 1'b1;
        default: qReg <= ~qReg;
      endcase
    end
  end

  assign qOut = qReg;
endmodule

// File: rtl/mod5_ctrl.sv
module mod5_ctrl
  import mod5_pkg::*;
(
  input  logic    rst,
  input  state_t  stateIn,
  output jkCtrl_t ctrlOut
);
  logic curA;
  logic curB;
  logic curC;

  assign curA = stateIn[BIT_A];
  assign curB = stateIn[BIT_B];
  assign curC = stateIn[BIT_C];

  always_comb begin
    ctrlOut       = '0;
    ctrlOut.clr   = rst;
    // Least significant stage runs only while the top bit is low
    ctrlOut.jIn[BIT_A] = ~curC;
    ctrlOut.kIn[BIT_A] = ~curC;
    // Middle stage follows the low bit
    ctrlOut.jIn[BIT_B] = curA;
    ctrlOut.kIn[BIT_B] = curA;
    // Top stage sets on 011-type patterns and always clears itself
    ctrlOut.jIn[BIT_C] = curA & curB;
    ctrlOut.kIn[BIT_C] = curC;
  end
endmodule

// File: rtl/mod5_dp.sv
module mod5_dp
  import mod5_pkg::*;
(
  input  logic    clk,
  input  jkCtrl_t ctrlIn,
  output state_t  stateQ
);
  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    mod5_jk_ff u_ff (
      .clk  (clk),
      .clr  (ctrlIn.clr),
      .jIn  (ctrlIn.jIn[i]),
      .kIn  (ctrlIn.kIn[i]),
      .qOut (stateQ[i])
    );
  end
endmodule

// File: rtl/mod5_jk_counter.sv
module mod5_jk_counter
  import mod5_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic outC,
  output logic outB,
  output logic outA
);
  state_t  curState;
  jkCtrl_t jkCtrl;

  mod5_ctrl u_ctrl (
    .rst     (rst),
    .stateIn (curState),
    .ctrlOut (jkCtrl)
  );

  mod5_dp u_dp (
    .clk    (clk),
    .ctrlIn (jkCtrl),
    .stateQ (curState)
  );

  assign outC = curState[BIT_C];
  assign outB = curState[BIT_B];
  assign outA = curState[BIT_A];
endmodule

// File: rtl/mod5_chk.sv
module mod5_chk (
  input logic clk,
  input logic rst,
  input logic outC,
  input logic outB,
  input logic outA
);
  logic [2:0] st;
  assign st = {outC, outB, outA};

  assert_a_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    !outC |=> outA != $past(outA));
  assert_a_hold_R2: assert property (@(posedge clk) disable iff (rst)
    outC |=> $stable(outA));
  assert_b_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    outA |=> outB != $past(outB));
  assert_b_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !outA |=> $stable(outB));
  assert_c_clear_R4: assert property (@(posedge clk) disable iff (rst)
    outC |=> !outC);
  assert_c_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!outC && outA && outB) |=> outC);
  assert_c_stay_R4: assert property (@(posedge clk) disable iff (rst)
    (!outC && !(outA && outB)) |=> !outC);
  assert_closed_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (st <= 3'd4) |=> (st <= 3'd4));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (st == 3'b100) |=> (st == 3'b000));
  assert_recover_101_R6: assert property (@(posedge clk) disable iff (rst)
    (st == 3'b101) |=> (st == 3'b011));
  assert_recover_110_R7: assert property (@(posedge clk) disable iff (rst)
    (st == 3'b110) |=> (st == 3'b010));
  assert_recover_111_R8: assert property (@(posedge clk) disable iff (rst)
    (st == 3'b111) |=> (st == 3'b001));
endmodule

bind mod5_jk_counter mod5_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .outC (outC),
  .outB (outB),
  .outA (outA)
);

// File: tb/mod5_jk_counter_tb.sv
`timescale 1ns/1ps
module mod5_jk_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outC, outB, outA;
  logic [2:0] injVal = 3'b000;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mod5_jk_counter u_dut (
    .clk  (clk),
    .rst  (rst),
    .outC (outC),
    .outB (outB),
    .outA (outA)
  );

  // Each entry: bit 3 = reset level for the edge, bits 2:0 = expected {C,B,A} after it
  localparam int NVEC = 18;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0_001, 4'b0_010, 4'b0_011, 4'b0_100, 4'b0_000,
    4'b0_001, 4'b0_010, 4'b0_011, 4'b0_100, 4'b0_000,
    4'b0_001, 4'b0_010, 4'b1_000, 4'b0_001, 4'b0_010,
    4'b0_011, 4'b1_000, 4'b0_001
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: state got %b expected %b", req, act, exp);
    end
  endtask

  // Reach an unused code: hold reset over the forced edge, then free both together
  task automatic inject(input string req, input logic [2:0] code, input logic [2:0] nxt);
    rst = 1'b1;
    @(negedge clk);
    injVal = code;
    force u_dut.u_dp.g_bit[0].u_ff.qReg = injVal[0];
    force u_dut.u_dp.g_bit[1].u_ff.qReg = injVal[1];
    force u_dut.u_dp.g_bit[2].u_ff.qReg = injVal[2];
    @(negedge clk);
    rst = 1'b0;
    release u_dut.u_dp.g_bit[0].u_ff.qReg;
    release u_dut.u_dp.g_bit[1].u_ff.qReg;
    release u_dut.u_dp.g_bit[2].u_ff.qReg;
    #1;
    check(req, {outC, outB, outA}, code);
    @(negedge clk);
    check(req, {outC, outB, outA}, nxt);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run got %0d cycles expected completion", 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] midVal;
    repeat (2) @(negedge clk);
    check("R1", {outC, outB, outA}, 3'b000);

    // Table walk: normal cycle over several wraps, with reset pulses mid-count
    for (int i = 0; i < NVEC; i++) begin
      rst = VEC[i][3];
      @(negedge clk);
      check(VEC[i][3] ? "R1" : "R5", {outC, outB, outA}, VEC[i][2:0]);
    end

    // R9: outputs stay put away from the rising edge
    #2 midVal = {outC, outB, outA};
    #2 check("R9", {outC, outB, outA}, midVal);

    // Unused codes and their single-step recovery
    inject("R6", 3'b101, 3'b011);
    @(negedge clk);
    check("R3", {outC, outB, outA}, 3'b100);
    inject("R7", 3'b110, 3'b010);
    inject("R8", 3'b111, 3'b001);

    // R4 / R2: 100 hold of A while C clears on the next edge
    inject("R2", 3'b100, 3'b000);

    // Reset priority from an unused code
    rst = 1'b1;
    @(negedge clk);
    injVal = 3'b111;
    force u_dut.u_dp.g_bit[0].u_ff.qReg = injVal[0];
    force u_dut.u_dp.g_bit[1].u_ff.qReg = injVal[1];
    force u_dut.u_dp.g_bit[2].u_ff.qReg = injVal[2];
    #1;
    release u_dut.u_dp.g_bit[0].u_ff.qReg;
    release u_dut.u_dp.g_bit[1].u_ff.qReg;
    release u_dut.u_dp.g_bit[2].u_ff.qReg;
    @(negedge clk);
    check("R1", {outC, outB, outA}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    check("R4", {outC, outB, outA}, 3'b001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule